// File: doc/BRIEF.md
# Rotating-Priority DMA Channel Scheduler

This block decides which of several DMA channels the shared transfer engine serves next. On every scheduling tick it either pays back part of the clock debt left by earlier transfers, or it runs one scheduling pass. A pass walks the channels in a fixed circular order from a start channel. Each eligible channel is handed to the engine through a valid/ready issue port. The scheduler then waits for the engine's result before it considers the next channel. A channel is eligible when its latched hardware request or its software request is set and its mask bit is clear.

A command word supplies three control bits, and their positions are fixed because the register block beside this one decodes the same word. Bit 2 turns the scheduler off. Bit 4 selects rotating priority, which moves the start channel on by one after every pass. Bit 8 is the hold bit: when it is set, one pass may serve several channels. The clocks that the engine reports during a pass are summed. At the end of the pass that sum is offered once on the stall output, so the processor can be held for that many clocks. The same sum also becomes the debt that later ticks pay back.

Issue port rules: `iss_valid` rises only in a pass. While `iss_valid` is high and `iss_ready` is low, `iss_valid` stays high and `iss_ch` stays fixed. The handshake completes on a clock edge where both are high. The engine then returns exactly one result with `res_valid`, no earlier than the cycle after the handshake. The result port has no back-pressure, and `res_valid` is ignored outside that wait. Ticks that arrive during a pass are dropped.

Top module: `dma_chan_sched`

## Requirements
- R1: After reset, `iss_valid` and `stall_valid` are low. The start channel is 0, the debt is 0, and no hardware request is latched.
- R2: A tick starts nothing while command bit 2 is set, or while every channel's mask bit is set.
- R3: With command bit 4 clear, every pass scans from channel 0 upward, so the lowest-numbered eligible channel is issued first.
- R4: With command bit 4 set, pass n scans from channel start, start+1, and so on, modulo the channel count. The start channel advances by one, with wrap, after every pass, including a pass that issued nothing.
- R5: With command bit 8 clear, a pass ends after the first result that has `res_performed` or `res_terminated` set. A result with neither flag set moves the scan on to the next eligible channel.
- R6: With command bit 8 set, a pass goes on through the remaining channels in scan order after every result, and issues each channel that is eligible.
- R7: At the end of a pass whose summed `res_clks` is nonzero, `stall_valid` is high for exactly one cycle and `stall_clks` carries the sum, which saturates at its maximum. A pass that costs nothing raises no stall.
- R8: The pass cost becomes the debt. Each later tick that finds debt above zero lowers it by the parameter MULT, stopping at zero, and starts no pass. The first tick that finds the debt at zero arbitrates.
- R9: Disabling the scheduler (command bit 2 set, or all channels masked) while no pass is running clears the debt and sets the start channel back to 0.
- R10: A rising edge on `hw_req[i]` latches request i, and a low level on `hw_req[i]` clears it. A result with `res_terminated` set for channel i also clears the latch, which is set again only by a new rising edge.
- R11: Eligibility, meaning (latched request OR `sw_req`) AND NOT `chan_mask`, is evaluated again at every scan step. A channel that loses its request or becomes masked during a pass is skipped.
- R12: `iss_valid` stays high with `iss_ch` unchanged until `iss_ready` is seen. A tick that arrives while a pass is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | CMD_W | Command word: bit 2 off, bit 4 rotate, bit 8 hold |
| sched_tick | input | 1 | Scheduling tick, one cycle wide |
| hw_req | input | NCH | Hardware request levels from the devices |
| sw_req | input | NCH | Software request bits |
| chan_mask | input | NCH | Per-channel mask bits, 1 = masked |
| iss_valid | output | 1 | Channel issue valid (start) |
| iss_ready | input | 1 | Engine accepts the issue |
| iss_ch | output | CH_W | Channel to service |
| res_valid | input | 1 | Engine result strobe |
| res_performed | input | 1 | Engine performed a transfer cycle |
| res_terminated | input | 1 | Engine terminated the channel |
| res_clks | input | CLK_W | Clocks spent by this cycle |
| stall_valid | output | 1 | One-cycle strobe with the cost of a pass |
| stall_clks | output | DEBT_W | Summed clocks of the finished pass |

## Verification
The bench targets the start channel after an empty pass. A design that rotated only after a serviced pass would issue channel 3 where channel 0 is due. It drives a debt that is not a multiple of MULT. A non-saturating counter would wrap and stall for thousands of ticks, and an off-by-one would arbitrate a tick early. It withdraws a request in the middle of a held pass, to catch a scheduler that fixes eligibility at the start of the pass and issues a dead channel. It also keeps a hardware request high after a termination, to catch a latch that re-arms on the level and serves the channel again.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

  // Command word bit positions shared with the register decoder.
  localparam int CMD_OFF_BIT    = 2;
  localparam int CMD_ROTATE_BIT = 4;
  localparam int CMD_HOLD_BIT   = 8;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_SCAN   = 3'd1,
    S_ISSUE  = 3'd2,
    S_WAIT   = 3'd3,
    S_FINISH = 3'd4
  } sched_state_e;

endpackage

// File: rtl/dma_req_latch.sv
module dma_req_latch #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hw_req,
  input  logic [NCH-1:0] term_clr,
  output logic [NCH-1:0] req_q
);

  logic [NCH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= hw_req;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)                       req_q[i] <= 1'b0;
      else if (!hw_req[i])              req_q[i] <= 1'b0;
      else if (hw_req[i] && !prev_q[i]) req_q[i] <= 1'b1;
      else if (term_clr[i])             req_q[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH  = 4,
  parameter int CH_W = 2,
  localparam int SW  = CH_W + 1
) (
  input  logic [NCH-1:0]  elig,
  input  logic [CH_W-1:0] base,
  input  logic [SW-1:0]   from_step,
  output logic            found,
  output logic [SW-1:0]   pick_step,
  output logic [CH_W-1:0] pick_ch
);

  always_comb begin
    found     = 1'b0;
    pick_step = '0;
    pick_ch   = '0;
    for (int k = 0; k < NCH; k++) begin
      int idx;
      idx = int'(base) + k;
      if (idx >= NCH) idx = idx - NCH;
      if (!found && (k >= int'(from_step)) && elig[idx]) begin
        found     = 1'b1;
        pick_step = SW'(k);
        pick_ch   = CH_W'(idx);
      end
    end
  end

endmodule

// File: rtl/dma_debt_acct.sv
module dma_debt_acct #(
  parameter int DEBT_W = 16,
  parameter int MULT   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [DEBT_W-1:0] load_val,
  input  logic              pay,
  output logic              has_debt
);

  localparam logic [DEBT_W-1:0] STEP = DEBT_W'(MULT);

  logic [DEBT_W-1:0] debt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     debt_q <= '0;
    else if (clr)   debt_q <= '0;
    else if (load)  debt_q <= load_val;
    else if (pay)   debt_q <= (debt_q > STEP) ? (debt_q - STEP) : '0;
  end

  assign has_debt = (debt_q != '0);

endmodule

// File: rtl/dma_chan_sched.sv
module dma_chan_sched
  import dma_sched_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CMD_W  = 16,
  parameter int CLK_W  = 8,
  parameter int DEBT_W = 16,
  parameter int MULT   = 1,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SW    = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              sched_tick,
  input  logic [NCH-1:0]    hw_req,
  input  logic [NCH-1:0]    sw_req,
  input  logic [NCH-1:0]    chan_mask,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [CH_W-1:0]   iss_ch,
  input  logic              res_valid,
  input  logic              res_performed,
  input  logic              res_terminated,
  input  logic [CLK_W-1:0]  res_clks,
  output logic              stall_valid,
  output logic [DEBT_W-1:0] stall_clks
);

  localparam logic [CH_W-1:0] LAST_CH   = CH_W'(NCH - 1);
  localparam logic [SW-1:0]   LAST_STEP = SW'(NCH - 1);

  sched_state_e      state_q;
  logic [CH_W-1:0]   start_q, base_q, ch_q;
  logic [SW-1:0]     step_q, cur_step_q;
  logic [DEBT_W-1:0] cost_q;
  logic [NCH-1:0]    req_q, elig, term_clr;
  logic              enabled, rotate, hold;
  logic              found, has_debt, pay, clr, load, stop_now;
  logic [SW-1:0]     pick_step;
  logic [CH_W-1:0]   pick_ch;
  logic [DEBT_W:0]   cost_sum;
  logic              unused_cmd;

  assign unused_cmd = ^cmd;
  assign enabled = !cmd[CMD_OFF_BIT] && (chan_mask != '1);
  assign rotate  = cmd[CMD_ROTATE_BIT];
  assign hold    = cmd[CMD_HOLD_BIT];
  assign elig    = (req_q | sw_req) & ~chan_mask & {NCH{enabled}};

  always_comb begin
    term_clr = '0;
    if (state_q == S_WAIT && res_valid && res_terminated) term_clr[ch_q] = 1'b1;
  end

  dma_req_latch #(.NCH(NCH)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_req   (hw_req),
    .term_clr (term_clr),
    .req_q    (req_q)
  );

  dma_prio_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
    .elig      (elig),
    .base      (base_q),
    .from_step (step_q),
    .found     (found),
    .pick_step (pick_step),
    .pick_ch   (pick_ch)
  );

  assign pay  = (state_q == S_IDLE) && sched_tick && enabled && has_debt;
  assign clr  = (state_q == S_IDLE) && !enabled;
  assign load = (state_q == S_FINISH);

  dma_debt_acct #(.DEBT_W(DEBT_W), .MULT(MULT)) u_debt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .load     (load),
    .load_val (cost_q),
    .pay      (pay),
    .has_debt (has_debt)
  );

  assign cost_sum = {1'b0, cost_q} + (DEBT_W + 1)'(res_clks);
  assign stop_now = ((res_performed || res_terminated) && !hold) || (cur_step_q == LAST_STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      start_q    <= '0;
      base_q     <= '0;
      ch_q       <= '0;
      step_q     <= '0;
      cur_step_q <= '0;
      cost_q     <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (!enabled) begin
            start_q <= '0;
          end else if (sched_tick && !has_debt) begin
            state_q <= S_SCAN;
            base_q  <= rotate ? start_q : '0;
            step_q  <= '0;
            cost_q  <= '0;
          end
        end
        S_SCAN: begin
          if (found) begin
            ch_q       <= pick_ch;
            cur_step_q <= pick_step;
            state_q    <= S_ISSUE;
          end else begin
            state_q    <= S_FINISH;
          end
        end
        S_ISSUE: begin
          if (iss_ready) state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (res_valid) begin
            cost_q <= cost_sum[DEBT_W] ? '1 : cost_sum[DEBT_W-1:0];
            if (stop_now) begin
              state_q <= S_FINISH;
            end else begin
              step_q  <= cur_step_q + SW'(1);
              state_q <= S_SCAN;
            end
          end
        end
        S_FINISH: begin
          state_q <= S_IDLE;
          if (rotate) start_q <= (start_q == LAST_CH) ? '0 : start_q + CH_W'(1);
          else        start_q <= '0;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign iss_valid   = (state_q == S_ISSUE);
  assign iss_ch      = ch_q;
  assign stall_valid = (state_q == S_FINISH) && (cost_q != '0);
  assign stall_clks  = stall_valid ? cost_q : '0;

endmodule

// File: rtl/dma_chan_sched_chk.sv
module dma_chan_sched_chk
  import dma_sched_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CH_W   = 2,
  parameter int DEBT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_off,
  input logic              sched_tick,
  input logic [NCH-1:0]    hw_req,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [CH_W-1:0]   iss_ch,
  input logic              stall_valid,
  input logic [DEBT_W-1:0] stall_clks,
  input sched_state_e      state_q,
  input logic [NCH-1:0]    elig,
  input logic [NCH-1:0]    req_q
);

  logic [NCH-1:0] prev_elig;
  always_ff @(posedge clk) begin
    if (!rst_n) prev_elig <= '0;
    else        prev_elig <= elig;
  end

  a_r2_off_no_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && sched_tick && cmd_off) |=> (state_q == S_IDLE));

  a_r7_stall_single: assert property (@(posedge clk) disable iff (!rst_n)
    stall_valid |=> !stall_valid);

  a_r7_stall_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    stall_valid |-> (stall_clks != '0));

  a_r10_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_q & ~$past(hw_req)) == '0));

  a_r11_issue_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iss_valid) |-> prev_elig[iss_ch]);

  a_r12_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_ch)));

endmodule

bind dma_chan_sched dma_chan_sched_chk #(
  .NCH(NCH), .CH_W(CH_W), .DEBT_W(DEBT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_off     (cmd[dma_sched_pkg::CMD_OFF_BIT]),
  .sched_tick  (sched_tick),
  .hw_req      (hw_req),
  .iss_valid   (iss_valid),
  .iss_ready   (iss_ready),
  .iss_ch      (iss_ch),
  .stall_valid (stall_valid),
  .stall_clks  (stall_clks),
  .state_q     (state_q),
  .elig        (elig),
  .req_q       (req_q)
);

// File: tb/dma_chan_sched_tb_top.sv
module dma_chan_sched_tb_top;

  localparam int NCH = 4, CMD_W = 16, CLK_W = 8, DEBT_W = 16, MULT = 2;
  localparam logic [15:0] C_OFF = 16'h0004, C_ROT = 16'h0010, C_HOLD = 16'h0100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CMD_W-1:0] cmd = '0;
  logic sched_tick = 0, iss_ready = 0, res_valid = 0, res_performed = 0, res_terminated = 0;
  logic [NCH-1:0] hw_req = '0, sw_req = '0, chan_mask = '0;
  logic [CLK_W-1:0] res_clks = '0;
  logic iss_valid, stall_valid;
  logic [1:0] iss_ch;
  logic [DEBT_W-1:0] stall_clks;
  int n_checks = 0, n_fail = 0;

  always #10 clk = ~clk;

  dma_chan_sched #(.NCH(NCH), .CMD_W(CMD_W), .CLK_W(CLK_W), .DEBT_W(DEBT_W), .MULT(MULT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .sched_tick(sched_tick),
    .hw_req(hw_req), .sw_req(sw_req), .chan_mask(chan_mask),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_ch(iss_ch),
    .res_valid(res_valid), .res_performed(res_performed),
    .res_terminated(res_terminated), .res_clks(res_clks),
    .stall_valid(stall_valid), .stall_clks(stall_clks));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_tick();
    @(negedge clk) sched_tick = 1'b1;
    @(negedge clk) sched_tick = 1'b0;
  endtask

  task automatic serve(input int ch, input bit perf, input bit term, input int clks, input string tag);
    int i;
    for (i = 0; i < 20; i++) begin
      if (iss_valid) break;
      @(negedge clk);
    end
    chk(iss_valid == 1'b1, {tag, " issue seen"}, int'(iss_valid), 1);
    if (!iss_valid) return;
    chk(int'(iss_ch) == ch, {tag, " channel"}, int'(iss_ch), ch);
    iss_ready = 1'b1;
    @(negedge clk) iss_ready = 1'b0;
    res_valid = 1'b1; res_performed = perf; res_terminated = term; res_clks = CLK_W'(clks);
    @(negedge clk) res_valid = 1'b0; res_performed = 0; res_terminated = 0; res_clks = '0;
  endtask

  task automatic no_issue(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      if (iss_valid) seen = 1;
      @(negedge clk);
    end
    chk(!seen, {tag, " no issue"}, int'(seen), 0);
  endtask

  task automatic wait_stall(input int exp, input string tag);
    bit seen = 0;
    int val = 0;
    for (int i = 0; i < 4; i++) begin
      if (stall_valid && !seen) begin seen = 1; val = int'(stall_clks); end
      @(negedge clk);
    end
    if (exp == 0) chk(!seen, {tag, " no stall"}, int'(seen), 0);
    else          chk(seen && val == exp, {tag, " stall cost"}, val, exp);
  endtask

  task automatic reset_sched();
    cmd = C_OFF; sw_req = '0; hw_req = '0; chan_mask = '0;
    settle(4);
  endtask

  task automatic t_reset();
    chk(iss_valid == 0, "R1 reset iss_valid", int'(iss_valid), 0);
    chk(stall_valid == 0, "R1 reset stall_valid", int'(stall_valid), 0);
    cmd = '0; do_tick(); no_issue(6, "R1 empty after reset");
  endtask

  task automatic t_fixed();
    reset_sched(); cmd = '0; sw_req = 4'b0110;
    do_tick(); serve(1, 1, 0, 0, "R3 lowest first"); settle(2);
    do_tick(); serve(1, 1, 0, 0, "R3 no rotation"); settle(2);
    sw_req = 4'b1000;
    do_tick(); serve(3, 1, 0, 0, "R3 only ch3"); settle(2);
  endtask

  task automatic t_disable();
    reset_sched(); sw_req = 4'b1111;
    do_tick(); no_issue(6, "R2 cmd off");
    cmd = '0; chan_mask = 4'b1111;
    do_tick(); no_issue(6, "R2 all masked");
    chan_mask = 4'b0001; sw_req = 4'b0011;
    do_tick(); serve(1, 1, 0, 0, "R2 partial mask"); settle(2);
  endtask

  task automatic t_rotate();
    reset_sched(); cmd = C_ROT; sw_req = 4'b1111;
    for (int p = 0; p < 5; p++) begin
      do_tick(); serve(p % 4, 1, 0, 0, "R4 rotate sequence"); settle(2);
    end
    sw_req = 4'b0001;
    do_tick(); serve(0, 1, 0, 0, "R4 start1 wraps to ch0"); settle(2);
    do_tick(); serve(0, 1, 0, 0, "R4 start2 wraps to ch0"); settle(2);
    sw_req = '0;
    do_tick(); no_issue(6, "R4 empty pass");
    sw_req = 4'b1001;
    do_tick(); serve(0, 1, 0, 0, "R4 empty pass advanced start"); settle(2);
  endtask

  task automatic t_hold();
    reset_sched(); cmd = C_HOLD; sw_req = 4'b1011;
    do_tick();
    serve(0, 1, 0, 1, "R6 hold first");
    serve(1, 1, 0, 2, "R6 hold second");
    serve(3, 1, 0, 1, "R6 hold third");
    wait_stall(4, "R7 summed cost");
    do_tick(); no_issue(4, "R8 pay 4->2");
    do_tick(); no_issue(4, "R8 pay 2->0");
    do_tick();
    serve(0, 1, 0, 0, "R8 arbitrates after payoff");
    serve(1, 1, 0, 0, "R6 hold again ch1");
    serve(3, 1, 0, 0, "R6 hold again ch3");
    wait_stall(0, "R7 zero cost");
  endtask

  task automatic t_nohold();
    reset_sched(); cmd = '0; sw_req = 4'b0011;
    do_tick();
    serve(0, 0, 0, 0, "R5 idle result continues");
    serve(1, 1, 0, 3, "R5 next channel");
    wait_stall(3, "R7 single cost");
    do_tick(); no_issue(4, "R8 pay 3->1");
    do_tick(); no_issue(4, "R8 saturate 1->0");
    do_tick(); serve(0, 1, 0, 0, "R8 third tick arbitrates");
    no_issue(6, "R5 stop after performed");
  endtask

  task automatic t_debt_clear();
    reset_sched(); cmd = '0; sw_req = 4'b0001;
    do_tick(); serve(0, 1, 0, 5, "R9 costly pass"); wait_stall(5, "R9 cost");
    cmd = C_OFF; settle(3); cmd = '0;
    do_tick(); serve(0, 1, 0, 0, "R9 debt cleared");
    settle(2);
    cmd = C_ROT; do_tick(); serve(0, 1, 0, 0, "R9 rot pass a"); settle(2);
    cmd = C_OFF; settle(3); cmd = C_ROT; sw_req = 4'b1111;
    do_tick(); serve(0, 1, 0, 0, "R9 start reset to 0"); settle(2);
  endtask

  task automatic t_skip();
    reset_sched(); cmd = C_HOLD; sw_req = 4'b0011;
    do_tick();
    for (int i = 0; i < 20; i++) begin
      if (iss_valid) break;
      @(negedge clk);
    end
    sw_req = 4'b0001;
    serve(0, 1, 0, 2, "R11 first of pass");
    wait_stall(2, "R11 pass ends");
    no_issue(4, "R11 withdrawn ch1 skipped");
  endtask

  task automatic t_hwreq();
    reset_sched(); cmd = '0; hw_req = 4'b0100; settle(2);
    do_tick(); serve(2, 1, 1, 0, "R10 rising edge latched"); settle(2);
    do_tick(); no_issue(6, "R10 terminated clears latch");
    hw_req = '0; settle(2); hw_req = 4'b0100; settle(2);
    do_tick(); serve(2, 1, 0, 0, "R10 new edge re-arms"); settle(2);
    hw_req = '0; settle(2);
    do_tick(); no_issue(6, "R10 low level clears");
  endtask

  task automatic t_handshake();
    bit ok = 1;
    reset_sched(); cmd = '0; sw_req = 4'b0100;
    do_tick();
    for (int i = 0; i < 20; i++) begin
      if (iss_valid) break;
      @(negedge clk);
    end
    for (int i = 0; i < 4; i++) begin
      if (!iss_valid || iss_ch != 2'd2) ok = 0;
      sched_tick = (i == 1);
      @(negedge clk);
    end
    sched_tick = 0;
    chk(ok, "R12 valid held without ready", int'(ok), 1);
    serve(2, 1, 0, 0, "R12 accepted");
    no_issue(6, "R12 tick during pass ignored");
  endtask

  initial begin
    settle(3); rst_n = 1'b1; settle(1);
    t_reset();
    t_fixed();
    t_disable();
    t_rotate();
    t_hold();
    t_nohold();
    t_debt_clear();
    t_skip();
    t_hwreq();
    t_handshake();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule